// File: doc/BRIEF.md
# Multi-Mode Serial Port with LIN Break

This block is a serial transmit and receive engine. One 8-bit control register selects how it works. In asynchronous mode and in LIN mode it sends and receives framed characters, using a fixed number of system clocks per bit. In synchronous mode it either drives its own serial clock as master or follows a clock supplied from outside as slave. In that mode, start and stop framing can be switched on or off. In LIN mode, software can ask for a synch break of 13 to 16 bit times.

Transmit data enters through a valid/ready handshake. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low while a word or a break is on the line, and also while a break request is waiting. Received words leave as a one-cycle `rx_valid` pulse together with `rx_data`. The receive side cannot apply back-pressure, so the consumer must take each word in the cycle it appears. Two flags, `tx_idle` and `rx_idle`, report when each line is quiet.

Top module: `msp_top`

## Requirements
- R1: In asynchronous mode (`cfg_wdata[1:0]`=0) and in LIN mode (`cfg_wdata[1:0]`=2), a word taken from the handshake is sent as follows: a low start bit, then the 8 data bits LSB first, then a high stop bit. Each bit lasts BIT_DIV clocks, so `tx_idle` is low for 10·BIT_DIV clocks. When idle, `txd` is high.
- R2: In asynchronous mode the receiver finds a low start bit and samples each bit near its middle. After a high stop bit it pulses `rx_valid` for one cycle with the byte. A low stop bit gives no word; the receiver then waits for the line to go high.
- R3: A register write in LIN mode with the break bit (`cfg_wdata[2]`) set drives `txd` low for (13+L)·BIT_DIV clocks, where L is `cfg_wdata[7:6]`. `tx_ready` is low during the break. The break bit clears itself when the break ends.
- R4: Outside LIN mode, the break bit is ignored: `txd` stays high and `tx_ready` stays high.
- R5: In synchronous mode (`cfg_wdata[1:0]`=1) as master (`cfg_wdata[3]`=1), `sclk_o` idles low. It gives one high pulse per bit, rising BIT_DIV/2 clocks into the bit. The receiver samples `rxd` at that rising point.
- R6: The master bit is forced to 0 in every mode other than synchronous mode, so `sclk_o` stays low there.
- R7: As synchronous master with the delay bit (`cfg_wdata[4]`) set, `sclk_o` is delayed by BIT_DIV/2 clocks, which is half a serial clock period. The data timing is unchanged.
- R8: In synchronous mode, the framing bit (`cfg_wdata[5]`) adds a start bit and a stop bit, giving 10 bits instead of 8. The framing bit is ignored in the other modes, which always send 10 bits.
- R9: As synchronous slave (master bit 0), `sclk_o` stays low. The transmitter shows the first bit as soon as the word is loaded and moves to the next bit on each falling edge of `sclk_i`. The receiver samples on each rising edge of `sclk_i`.
- R10: `tx_idle` and `rx_idle` are high after reset and while their line is quiet. Each goes low once a start bit or a break begins. Each returns high after the stop bit, or after a break once the line is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control word: [1:0] mode, [2] break, [3] master, [4] clock delay, [5] framing, [7:6] break length |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DATA_W | Transmit word |
| tx_ready | output | 1 | Transmitter can take a word |
| rxd | input | 1 | Serial data in |
| sclk_i | input | 1 | Serial clock in (slave) |
| txd | output | 1 | Serial data out |
| sclk_o | output | 1 | Serial clock out (master) |
| rx_data | output | DATA_W | Received word |
| rx_valid | output | 1 | One-cycle pulse with a received word |
| tx_idle | output | 1 | Transmit line quiet |
| rx_idle | output | 1 | Receive line quiet |

## Verification
Slave operation is the hardest case to reach. The clock then comes from outside, passes through a synchronizer, and has to move transmit and receive bits at the same time. The bench drives `sclk_i` slowly by hand. It sets the receive bit ahead of each rising edge and checks the transmit bit just before that edge, after the previous falling edge has had time to propagate. The LIN break is fed back into the receiver through a loopback on `txd`. This shows that the receiver holds `rx_idle` low, reports no word, and recovers once the line goes high again.

// File: rtl/msp_pkg.sv
package msp_pkg;
  typedef enum logic [1:0] {
    MD_ASYNC = 2'd0,
    MD_SYNC  = 2'd1,
    MD_LIN   = 2'd2,
    MD_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_BREAK} tx_st_e;

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_WAIT} rx_st_e;
endpackage

// File: rtl/msp_sync.sv
module msp_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/msp_tx.sv
module msp_tx
  import msp_pkg::*;
#(
  parameter int BIT_DIV  = 8,
  parameter int DATA_W   = 8,
  parameter int BRK_BASE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_md,
  input  logic              master,
  input  logic              framed,
  input  logic              dly_en,
  input  logic              slave_fall,
  input  logic              brk_req,
  input  logic [1:0]        brk_len,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              brk_done,
  output logic              txd,
  output logic              tx_idle,
  output logic              sclk_o,
  output logic              samp_m
);
  localparam int HALF = BIT_DIV / 2;
  localparam int CW   = $clog2(BIT_DIV);
  localparam int FW   = DATA_W + 2;
  localparam int NW   = $clog2(FW + 1);
  localparam int BW   = $clog2(BRK_BASE + 4);
  localparam logic [CW-1:0] CNT_MAX  = CW'(BIT_DIV - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF);

  tx_st_e          st;
  logic [CW-1:0]   cnt;
  logic [FW-1:0]   fr;
  logic [NW-1:0]   nleft;
  logic [BW-1:0]   bcnt, blast;
  logic [HALF-1:0] dly_sr;
  logic            slave, bit_end, step, sclk_raw;

  assign slave    = sync_md & ~master;
  assign bit_end  = (cnt == CNT_MAX);
  assign step     = slave ? slave_fall : bit_end;
  assign blast    = BW'(BRK_BASE - 1) + BW'(brk_len);
  assign brk_done = (st == T_BREAK) & bit_end & (bcnt == blast);
  assign tx_ready = (st == T_IDLE) & ~brk_req;
  assign tx_idle  = (st == T_IDLE);
  assign txd      = (st == T_SHIFT) ? fr[0] : (st != T_BREAK);
  assign sclk_raw = (st == T_SHIFT) & sync_md & master & (cnt >= CNT_HALF);
  assign samp_m   = (st == T_SHIFT) & sync_md & master & (cnt == CNT_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= T_IDLE;
      cnt   <= '0;
      fr    <= '1;
      nleft <= '0;
      bcnt  <= '0;
    end else begin
      case (st)
        T_IDLE: begin
          cnt <= '0;
          if (brk_req) begin
            st   <= T_BREAK;
            bcnt <= '0;
          end else if (tx_valid) begin
            st    <= T_SHIFT;
            nleft <= framed ? NW'(FW) : NW'(DATA_W);
            fr    <= framed ? {1'b1, tx_data, 1'b0} : {2'b11, tx_data};
          end
        end
        T_SHIFT: begin
          if (!slave) cnt <= bit_end ? '0 : cnt + 1'b1;
          if (step) begin
            fr    <= {1'b1, fr[FW-1:1]};
            nleft <= nleft - 1'b1;
            if (nleft == NW'(1)) st <= T_IDLE;
          end
        end
        T_BREAK: begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == blast) st <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // half-period delay line for the optional shifted master clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_sr <= '0;
    end else begin
      dly_sr[0] <= sclk_raw;
      for (int i = 1; i < HALF; i++) dly_sr[i] <= dly_sr[i-1];
    end
  end

  assign sclk_o = dly_en ? dly_sr[HALF-1] : sclk_raw;
endmodule

// File: rtl/msp_rx.sv
module msp_rx
  import msp_pkg::*;
#(
  parameter int BIT_DIV = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxs,
  input  logic              sync_md,
  input  logic              framed,
  input  logic              samp,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_idle
);
  localparam int HALF = BIT_DIV / 2;
  localparam int CW   = $clog2(BIT_DIV);
  localparam int BNW  = $clog2(DATA_W);
  localparam logic [CW-1:0]  CNT_MAX  = CW'(BIT_DIV - 1);
  localparam logic [CW-1:0]  CNT_HM1  = CW'(HALF - 1);
  localparam logic [BNW-1:0] BIT_LAST = BNW'(DATA_W - 1);

  rx_st_e            st;
  logic [CW-1:0]     cnt;
  logic [BNW-1:0]    bitn;
  logic [DATA_W-1:0] sh, nxt_sh;
  logic              bit_end, ev;

  assign bit_end = (cnt == CNT_MAX);
  assign ev      = sync_md ? samp : bit_end;
  assign nxt_sh  = {rxs, sh[DATA_W-1:1]};
  assign rx_idle = (st == R_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= R_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        R_IDLE: begin
          cnt <= '0;
          if (sync_md) begin
            if (samp) begin
              if (!framed) begin
                sh   <= nxt_sh;
                bitn <= BNW'(1);
                st   <= R_DATA;
              end else if (!rxs) begin
                bitn <= '0;
                st   <= R_DATA;
              end
            end
          end else if (!rxs) begin
            st <= R_START;
          end
        end
        R_START: begin
          if (cnt == CNT_HM1) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rxs ? R_IDLE : R_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        R_DATA: begin
          if (!sync_md) cnt <= bit_end ? '0 : cnt + 1'b1;
          if (ev) begin
            sh   <= nxt_sh;
            bitn <= bitn + 1'b1;
            if (bitn == BIT_LAST) begin
              if (framed) begin
                st <= R_STOP;
              end else begin
                st       <= R_IDLE;
                rx_data  <= nxt_sh;
                rx_valid <= 1'b1;
              end
            end
          end
        end
        R_STOP: begin
          if (!sync_md) cnt <= bit_end ? '0 : cnt + 1'b1;
          if (ev) begin
            if (rxs) begin
              rx_data  <= sh;
              rx_valid <= 1'b1;
              st       <= R_IDLE;
            end else begin
              st <= sync_md ? R_IDLE : R_WAIT;
            end
          end
        end
        R_WAIT: if (rxs) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msp_top.sv
module msp_top
  import msp_pkg::*;
#(
  parameter int BIT_DIV  = 8,
  parameter int DATA_W   = 8,
  parameter int BRK_BASE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rxd,
  input  logic              sclk_i,
  output logic              txd,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_idle,
  output logic              rx_idle
);
  mode_e      cfg_mode, wr_mode;
  logic       brk_req, cfg_master, cfg_dly, cfg_frame;
  logic [1:0] cfg_blen;
  logic       brk_done, brk_keep, sync_md, framed, dly_en;
  logic       rxs, sck_s, sck_q, sck_rise, sck_fall, samp_m, samp;

  assign wr_mode  = mode_e'(cfg_wdata[1:0]);
  assign brk_keep = brk_req & ~brk_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode   <= MD_ASYNC;
      brk_req    <= 1'b0;
      cfg_master <= 1'b0;
      cfg_dly    <= 1'b0;
      cfg_frame  <= 1'b0;
      cfg_blen   <= 2'd0;
    end else if (cfg_we) begin
      cfg_mode   <= wr_mode;
      brk_req    <= (brk_keep | cfg_wdata[2]) & (wr_mode == MD_LIN);
      cfg_master <= cfg_wdata[3] & (wr_mode == MD_SYNC);
      cfg_dly    <= cfg_wdata[4];
      cfg_frame  <= cfg_wdata[5];
      cfg_blen   <= cfg_wdata[7:6];
    end else begin
      brk_req <= brk_keep;
    end
  end

  assign sync_md = (cfg_mode == MD_SYNC);
  assign framed  = ~sync_md | cfg_frame;
  assign dly_en  = cfg_dly & cfg_master;

  msp_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_i, rxd}), .q({sck_s, rxs})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign samp     = cfg_master ? samp_m : sck_rise;

  msp_tx #(.BIT_DIV(BIT_DIV), .DATA_W(DATA_W), .BRK_BASE(BRK_BASE)) u_tx (
    .clk(clk), .rst_n(rst_n), .sync_md(sync_md), .master(cfg_master),
    .framed(framed), .dly_en(dly_en), .slave_fall(sck_fall),
    .brk_req(brk_req), .brk_len(cfg_blen), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .brk_done(brk_done),
    .txd(txd), .tx_idle(tx_idle), .sclk_o(sclk_o), .samp_m(samp_m)
  );

  msp_rx #(.BIT_DIV(BIT_DIV), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxs(rxs), .sync_md(sync_md),
    .framed(framed), .samp(samp), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_idle(rx_idle)
  );
endmodule

// File: rtl/msp_chk.sv
module msp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       brk_req,
  input logic       cfg_we,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_idle,
  input logic       txd,
  input logic       sclk_o,
  input logic       rx_valid
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_idle);

  p_rx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_brk_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(brk_req) && !$past(cfg_we)) |-> tx_idle);

  p_no_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> !brk_req);

  p_sclk_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd1) |-> !sclk_o);
endmodule

bind msp_top msp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .brk_req(brk_req),
  .cfg_we(cfg_we), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_idle(tx_idle), .txd(txd), .sclk_o(sclk_o), .rx_valid(rx_valid)
);

// File: tb/sim_msp_top.sv
module sim_msp_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_DIV    = 8;
  localparam int HALF       = BIT_DIV / 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rxd_drv = 1'b1, sclk_i = 1'b0, loop = 1'b0;
  logic       rxd, tx_ready, txd, sclk_o, rx_valid, tx_idle, rx_idle;
  logic [7:0] rx_data;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_exp;

  assign rxd = loop ? txd : rxd_drv;
  always #(CLK_PERIOD/2) clk = ~clk;

  msp_top #(.BIT_DIV(BIT_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rxd(rxd), .sclk_i(sclk_i), .txd(txd), .sclk_o(sclk_o),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_idle(tx_idle), .rx_idle(rx_idle)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R2 unexpected word: actual %0h expected none", rx_data);
      end else begin
        mon_exp = exp_q.pop_front();
        chk("R2", "received word", int'(rx_data), int'(mon_exp));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  task automatic wr_cfg(input int md, input bit brk, input bit mst, input bit dly,
                        input bit frm, input int len);
    @(negedge clk);
    cfg_wdata = {2'(len), frm, dly, mst, brk, 2'(md)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    for (int w = 0; w < 400 && !tx_ready; w++) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // driver: sends a word, pushes expectation, measures the line
  task automatic send_meas(input logic [7:0] b, input bit expect_rx, output int busy,
                           output int pulses, output int first_rise,
                           output logic [9:0] fb, output logic rx_mid);
    logic prev;
    if (expect_rx) exp_q.push_back(b);
    push_tx(b);
    busy = 0; pulses = 0; first_rise = -1; fb = '1; prev = 1'b0; rx_mid = 1'b1;
    for (int k = 0; k < 400; k++) begin
      if (!tx_idle) busy++;
      if (sclk_o && !prev) begin
        pulses++;
        if (first_rise < 0) first_rise = k;
      end
      prev = sclk_o;
      if (k % BIT_DIV == HALF && k / BIT_DIV < 10) fb[k / BIT_DIV] = txd;
      if (k == 5 * BIT_DIV) rx_mid = rx_idle;
      if (tx_idle && k >= busy + 2 * BIT_DIV) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int busy, pulses, fr1, lowc;
    logic [9:0] fb;
    logic rxm;
    logic [7:0] abytes[4] = '{8'h35, 8'h00, 8'hFF, 8'hC1};
    logic [7:0] sbyte, rbyte;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset txd", int'(txd), 1);
    chk("R10", "reset tx_idle", int'(tx_idle), 1);
    chk("R10", "reset rx_idle", int'(rx_idle), 1);
    chk("R5", "reset sclk_o", int'(sclk_o), 0);
    chk("R1", "reset tx_ready", int'(tx_ready), 1);
    chk("R2", "reset rx_valid", int'(rx_valid), 0);

    // asynchronous loopback
    loop = 1'b1;
    wr_cfg(0, 0, 0, 0, 1, 0);
    foreach (abytes[i]) begin
      send_meas(abytes[i], 1'b1, busy, pulses, fr1, fb, rxm);
      chk("R1", "async busy clocks", busy, 10 * BIT_DIV);
      chk("R1", "async frame bits", int'(fb), int'({1'b1, abytes[i], 1'b0}));
      chk("R10", "rx_idle mid frame", int'(rxm), 0);
      chk("R10", "tx_idle after frame", int'(tx_idle), 1);
      chk("R10", "rx_idle after frame", int'(rx_idle), 1);
    end

    // master and framing bits in asynchronous mode
    wr_cfg(0, 0, 1, 0, 0, 0);
    send_meas(8'h5C, 1'b1, busy, pulses, fr1, fb, rxm);
    chk("R6", "async sclk pulses with master set", pulses, 0);
    chk("R8", "async busy with framing off", busy, 10 * BIT_DIV);

    // break bit outside LIN mode
    wr_cfg(0, 1, 0, 0, 0, 0);
    lowc = 0;
    for (int k = 0; k < 30; k++) begin
      if (!txd || !tx_idle) lowc++;
      @(negedge clk);
    end
    chk("R4", "async break ignored, low cycles", lowc, 0);
    chk("R4", "tx_ready after ignored break", int'(tx_ready), 1);

    // LIN data frame
    wr_cfg(2, 0, 0, 0, 0, 0);
    send_meas(8'h81, 1'b1, busy, pulses, fr1, fb, rxm);
    chk("R1", "LIN frame bits", int'(fb), int'({1'b1, 8'h81, 1'b0}));

    // LIN breaks of every length
    for (int len = 0; len < 4; len++) begin
      wr_cfg(2, 1, 0, 0, 0, len);
      for (int w = 0; w < 20 && txd; w++) @(negedge clk);
      lowc = 0;
      while (!txd && lowc < 400) begin
        lowc++;
        if (lowc == 20) begin
          chk("R3", "tx_ready during break", int'(tx_ready), 0);
          chk("R10", "tx_idle during break", int'(tx_idle), 0);
        end
        if (lowc == 50) chk("R10", "rx_idle during break", int'(rx_idle), 0);
        @(negedge clk);
      end
      chk("R3", "break low clocks", lowc, (13 + len) * BIT_DIV);
      repeat (6) @(negedge clk);
      chk("R3", "tx_ready after break", int'(tx_ready), 1);
      chk("R10", "rx_idle after break", int'(rx_idle), 1);
    end
    send_meas(8'h55, 1'b1, busy, pulses, fr1, fb, rxm);
    chk("R2", "frame after break busy", busy, 10 * BIT_DIV);

    // synchronous master, unframed
    wr_cfg(1, 0, 1, 0, 0, 0);
    send_meas(8'h96, 1'b1, busy, pulses, fr1, fb, rxm);
    chk("R5", "sync busy clocks", busy, 8 * BIT_DIV);
    chk("R5", "sync clock pulses", pulses, 8);
    chk("R5", "first rise offset", fr1, HALF);
    chk("R5", "sync data bits", int'(fb[7:0]), 8'h96);

    // synchronous master, delayed clock
    wr_cfg(1, 0, 1, 1, 0, 0);
    send_meas(8'h3A, 1'b1, busy, pulses, fr1, fb, rxm);
    chk("R7", "delayed first rise", fr1, 2 * HALF);
    chk("R7", "delayed pulses", pulses, 8);
    chk("R7", "delayed data bits", int'(fb[7:0]), 8'h3A);

    // synchronous master, framed
    wr_cfg(1, 0, 1, 0, 1, 0);
    send_meas(8'h4B, 1'b1, busy, pulses, fr1, fb, rxm);
    chk("R8", "framed sync busy", busy, 10 * BIT_DIV);
    chk("R8", "framed sync pulses", pulses, 10);
    chk("R8", "framed sync bits", int'(fb), int'({1'b1, 8'h4B, 1'b0}));

    // break bit in synchronous mode, then slave operation
    loop = 1'b0;
    wr_cfg(1, 1, 0, 0, 0, 0);
    lowc = 0;
    for (int k = 0; k < 30; k++) begin
      if (!txd) lowc++;
      @(negedge clk);
    end
    chk("R4", "sync break ignored, low cycles", lowc, 0);

    sbyte = 8'h2D; rbyte = 8'hC6;
    exp_q.push_back(rbyte);
    push_tx(sbyte);
    for (int i = 0; i < 8; i++) begin
      repeat (8) @(negedge clk);
      chk("R9", "slave tx bit", int'(txd), int'(sbyte[i]));
      rxd_drv = rbyte[i];
      repeat (4) @(negedge clk);
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9", "slave sclk_o quiet", int'(sclk_o), 0);
      sclk_i = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk("R9", "slave tx done", int'(tx_idle), 1);
    rxd_drv = 1'b1;

    repeat (10) @(negedge clk);
    chk("R2", "all expected words delivered", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule